// File: doc/BRIEF.md
# Streaming Top-8 Maximum Extractor

This unit watches a stream of single-precision floating-point values that make up one row and keeps a running, descending list of the eight largest values seen so far. A row opens with an element that carries the start marker and closes with an element that carries the end marker. At the close the unit raises a one-cycle completion pulse. The eight results then stay on the output until another row is opened.

Every accepted element is compared against all eight stored entries in the same cycle. It drops into its rank, the entries below it move down one place, and the smallest entry falls out. One element can be taken on every clock, so rows may be sent back to back or with idle gaps between elements.

The row length is counted as elements arrive. At the close it is checked against the legal range of 8 to 16384 elements and against the length that was configured when the row opened. Any violation sets an error flag, which appears together with the completion pulse.

The controller has four named states:
- IDLE (after reset).
- COLLECT (a row is open).
- REPORT (the one-cycle completion state).
- HOLD (results held).

Its transitions are:
- ROW_OPEN: any state goes to COLLECT on an accepted start element.
- ROW_SINGLE: any state goes to REPORT on an element that carries both markers.
- ROW_CLOSE: COLLECT goes to REPORT on an end element.
- REPORT_DONE: REPORT goes to HOLD.

Top module: `rowmax8_unit`

## Requirements
- R1: After a row closes, `top_vals` holds the eight largest values of that row, with entry k at bits [32k+31:32k] and entry 0 the largest, in descending order.
- R2: Ordering follows IEEE single-precision value: a positive value outranks a negative one, a larger magnitude ranks higher among positives, and a smaller magnitude ranks higher among negatives.
- R3: Repeated values each take a separate entry, and a value equal to one already stored is placed below it, so equal values keep their arrival order.
- R4: Negative zero (0x80000000) and positive zero rank equal and are ordered by arrival like any other tie.
- R5: An accepted start element clears all eight entries to the most negative finite value 0xFF7FFFFF before it is inserted, so a row shorter than eight leaves that value in the unused entries.
- R6: One element is accepted on every clock on which `in_valid` is high inside an open row, and cycles with `in_valid` low are not counted.
- R7: `done` is high for exactly the one cycle after the clock edge that accepts the end element.
- R8: After completion, `top_vals` and `err` do not change until the next start element, and `in_valid` elements without a start marker are ignored in that interval.
- R9: A row of fewer than 8 elements sets `err`, which is visible together with `done`.
- R10: A row of more than 16384 elements sets `err`, while rows of exactly 8 and exactly 16384 matching elements leave `err` low.
- R11: A row whose element count differs from `cfg_len`, as sampled with the start element, sets `err`.
- R12: A start element that arrives while a row is open discards that row and begins a new one.
- R13: After reset, `done` and `err` are low and all eight entries read 0xFF7FFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Element present on `in_data` |
| in_sor | input | 1 | Element is the first of a row |
| in_eor | input | 1 | Element is the last of a row |
| in_data | input | 32 | Element as an fp32 bit pattern |
| cfg_len | input | 15 | Expected row length, sampled with the start element |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Row length fault, held with the results |
| top_vals | output | 256 | Eight fp32 results, entry 0 (largest) in bits 31:0 |

## Verification
The search is tried with the following input patterns, each of which separates a different kind of fault:
- Rising positive runs, which force every new element to the top entry.
- Falling negative runs, which show whether the negative ordering is inverted correctly.
- Hashed mixed-sign data, which lands elements at every rank.
- Rows built from a small set of repeated values, which expose an insertion that is not stable.
- Rows of signed zeros, which show whether -0 and +0 are treated as a tie in arrival order.

Rows with idle gaps and rows sent without gaps check that only valid cycles are counted. Length faults are driven at 7, 8, 16384 and 16385 elements and with a wrong configured length. An aborted row followed by a fresh start checks that the abandoned data leaves no trace.

// File: rtl/rowmax8_pkg.sv
package rowmax8_pkg;

    localparam int unsigned SLOTS  = 8;
    localparam int unsigned WORD_W = 32;

    localparam logic [WORD_W-1:0] FP_FLOOR = 32'hFF7F_FFFF;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_REPORT  = 2'd2,
        ST_HOLD    = 2'd3
    } rm_state_e;

    // Map an fp32 pattern to an unsigned key with the same order; -0 folds onto +0.
    function automatic word_t order_key(input word_t x);
        word_t v;
        v = (x == 32'h8000_0000) ? 32'h0 : x;
        return v[31] ? ~v : {1'b1, v[30:0]};
    endfunction

endpackage

// File: rtl/rowmax8_ctrl.sv
module rowmax8_ctrl
    import rowmax8_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_sor,
    input  logic in_eor,
    output logic accept,
    output logic clear,
    output logic last,
    output logic done
);

    rm_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (in_valid && in_sor) begin
            state_d = in_eor ? ST_REPORT : ST_COLLECT;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_IDLE;
                ST_COLLECT: state_d = (in_valid && in_eor) ? ST_REPORT : ST_COLLECT;
                ST_REPORT:  state_d = ST_HOLD;
                ST_HOLD:    state_d = ST_HOLD;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        accept = 1'b0;
        done   = 1'b0;
        unique case (state_q)
            ST_IDLE:    accept = in_valid && in_sor;
            ST_COLLECT: accept = in_valid;
            ST_REPORT: begin
                accept = in_valid && in_sor;
                done   = 1'b1;
            end
            ST_HOLD:    accept = in_valid && in_sor;
            default:    accept = 1'b0;
        endcase
        clear = accept && in_sor;
        last  = accept && in_eor;
    end

endmodule

// File: rtl/rowmax8_sortreg.sv
module rowmax8_sortreg
    import rowmax8_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    accept,
    input  logic                    clear,
    input  word_t                   din,
    output logic [SLOTS*WORD_W-1:0] slots_flat
);

    word_t             slot_q [SLOTS];
    word_t             base   [SLOTS];
    word_t             nxt    [SLOTS];
    logic  [SLOTS-1:0] above;
    word_t             new_key;

    assign new_key = order_key(din);

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        assign base[i]  = clear ? FP_FLOOR : slot_q[i];
        // Strictly greater only: an equal value ranks below the stored one.
        assign above[i] = new_key > order_key(base[i]);

        if (i == 0) begin : g_top
            assign nxt[i] = above[i] ? din : base[i];
        end else begin : g_rest
            assign nxt[i] = !above[i]    ? base[i] :
                            above[i-1]   ? base[i-1] : din;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      slot_q[i] <= FP_FLOOR;
            else if (accept) slot_q[i] <= nxt[i];
        end

        assign slots_flat[i*WORD_W +: WORD_W] = slot_q[i];
    end

endmodule

// File: rtl/rowmax8_lencheck.sv
module rowmax8_lencheck #(
    parameter int unsigned MIN_LEN = 8,
    parameter int unsigned MAX_LEN = 16384,
    parameter int unsigned CNT_W   = $clog2(MAX_LEN + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             clear,
    input  logic             last,
    input  logic [CNT_W-1:0] cfg_len,
    output logic             err
);

    localparam logic [CNT_W-1:0] CAP  = CNT_W'(MAX_LEN + 1);
    localparam logic [CNT_W-1:0] LO   = CNT_W'(MIN_LEN);
    localparam logic [CNT_W-1:0] HI   = CNT_W'(MAX_LEN);

    logic [CNT_W-1:0] cnt_q, cnt_d, cfg_q, cfg_eff;
    logic             err_q, bad_len;

    always_comb begin
        if (clear)           cnt_d = CNT_W'(1);
        else if (cnt_q >= CAP) cnt_d = CAP;
        else                 cnt_d = cnt_q + CNT_W'(1);
        cfg_eff = clear ? cfg_len : cfg_q;
        bad_len = (cnt_d < LO) || (cnt_d > HI) || (cnt_d != cfg_eff);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cfg_q <= '0;
            err_q <= 1'b0;
        end else if (accept) begin
            cnt_q <= cnt_d;
            if (clear) cfg_q <= cfg_len;
            if (last)       err_q <= bad_len;
            else if (clear) err_q <= 1'b0;
        end
    end

    assign err = err_q;

endmodule

// File: rtl/rowmax8_unit.sv
module rowmax8_unit
    import rowmax8_pkg::*;
#(
    parameter int unsigned MIN_LEN = 8,
    parameter int unsigned MAX_LEN = 16384,
    parameter int unsigned CNT_W   = $clog2(MAX_LEN + 2)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_sor,
    input  logic                    in_eor,
    input  logic [WORD_W-1:0]       in_data,
    input  logic [CNT_W-1:0]        cfg_len,
    output logic                    done,
    output logic                    err,
    output logic [SLOTS*WORD_W-1:0] top_vals
);

    logic accept, clear, last;

    rowmax8_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sor   (in_sor),
        .in_eor   (in_eor),
        .accept   (accept),
        .clear    (clear),
        .last     (last),
        .done     (done)
    );

    rowmax8_sortreg u_sort (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .clear      (clear),
        .din        (in_data),
        .slots_flat (top_vals)
    );

    rowmax8_lencheck #(
        .MIN_LEN (MIN_LEN),
        .MAX_LEN (MAX_LEN),
        .CNT_W   (CNT_W)
    ) u_len (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .clear   (clear),
        .last    (last),
        .cfg_len (cfg_len),
        .err     (err)
    );

endmodule

// File: rtl/rowmax8_checker.sv
module rowmax8_checker
    import rowmax8_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    in_sor,
    input logic                    in_eor,
    input logic                    done,
    input logic                    err,
    input logic [SLOTS*WORD_W-1:0] top_vals
);

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(in_valid && in_eor));

    p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !(in_valid && in_sor)) |=> ($stable(top_vals) && $stable(err)));

    p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done);

    p_clear_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sor) |=> (top_vals[SLOTS*WORD_W-1:WORD_W] == {(SLOTS-1){FP_FLOOR}}));

    for (genvar k = 0; k < SLOTS - 1; k++) begin : g_ord
        p_desc_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
            order_key(top_vals[k*WORD_W +: WORD_W]) >= order_key(top_vals[(k+1)*WORD_W +: WORD_W]));
    end

endmodule

bind rowmax8_unit rowmax8_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_sor   (in_sor),
    .in_eor   (in_eor),
    .done     (done),
    .err      (err),
    .top_vals (top_vals)
);

// File: tb/rowmax8_unit_tb_top.sv
module rowmax8_unit_tb_top;

    localparam logic [31:0] FLOOR = 32'hFF7F_FFFF;
    localparam int BUF_N = 16400;

    typedef struct packed {
        logic [2:0]  pat;
        logic [7:0]  seed;
        logic [14:0] len;
        logic [14:0] cfg;
        logic        gap;
    } row_t;

    localparam int N_ROWS = 10;
    localparam row_t ROWS [N_ROWS] = '{
        '{3'd0, 8'd1,  15'd20,  15'd20,  1'b0},   // rising positives
        '{3'd1, 8'd2,  15'd8,   15'd8,   1'b0},   // negatives, minimum length
        '{3'd2, 8'd3,  15'd300, 15'd300, 1'b1},   // mixed, gaps
        '{3'd3, 8'd4,  15'd50,  15'd50,  1'b0},   // duplicates
        '{3'd4, 8'd5,  15'd30,  15'd30,  1'b1},   // signed zeros
        '{3'd2, 8'd9,  15'd9,   15'd9,   1'b0},
        '{3'd5, 8'd6,  15'd12,  15'd12,  1'b0},   // floor values present
        '{3'd0, 8'd7,  15'd7,   15'd7,   1'b0},   // too short
        '{3'd1, 8'd8,  15'd25,  15'd24,  1'b0},   // cfg mismatch
        '{3'd3, 8'd10, 15'd3,   15'd3,   1'b1}    // short, floor padding
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sor = 1'b0, in_eor = 1'b0;
    logic [31:0] in_data = '0;
    logic [14:0] cfg_len = '0;
    logic        done, err;
    logic [255:0] top_vals;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] rowbuf [BUF_N];
    bit          used   [BUF_N];
    logic [31:0] expv   [8];

    always #5 clk = ~clk;

    rowmax8_unit dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sor   (in_sor),
        .in_eor   (in_eor),
        .in_data  (in_data),
        .cfg_len  (cfg_len),
        .done     (done),
        .err      (err),
        .top_vals (top_vals)
    );

    function automatic logic [31:0] gen(input logic [2:0] pat, input logic [7:0] seed, input int i);
        logic [31:0] h;
        h = 32'(i) * 32'h9E37_79B1 + {24'd0, seed} * 32'h0101_0101;
        case (pat)
            3'd0: return {1'b0, 8'(100 + (i % 60)), 23'(i * 37)};
            3'd1: return {1'b1, 8'(90 + (i % 40)), 23'(i * 101)};
            3'd2: return {h[31], 2'b01, h[28:0]};
            3'd3: return {(i % 5 == 0), 8'd127, 2'(i % 4), 21'd0};
            3'd4: return (i % 7 == 0) ? 32'hBF80_0000 : ((i % 2 != 0) ? 32'h8000_0000 : 32'h0);
            default: return (i % 3 == 0) ? FLOOR : {1'b1, 8'd200, 23'(i)};
        endcase
    endfunction

    // a ranks strictly above b in real-number order (signed zeros equal)
    function automatic bit ranks_above(input logic [31:0] a, input logic [31:0] b);
        bit za, zb, na, nb;
        za = (a[30:0] == 0);
        zb = (b[30:0] == 0);
        if (za && zb) return 1'b0;
        na = a[31] && !za;
        nb = b[31] && !zb;
        if (na != nb) return nb;
        if (!na) return a[30:0] > b[30:0];
        return a[30:0] < b[30:0];
    endfunction

    task automatic build_expect(input int len);
        for (int j = 0; j < len; j++) used[j] = 1'b0;
        for (int k = 0; k < 8; k++) begin
            int best;
            best = -1;
            for (int j = 0; j < len; j++)
                if (!used[j] && (best < 0 || ranks_above(rowbuf[j], rowbuf[best]))) best = j;
            if (best < 0) expv[k] = FLOOR;
            else begin
                expv[k] = rowbuf[best];
                used[best] = 1'b1;
            end
        end
    endtask

    task automatic check1(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_row(input logic [2:0] pat, input logic [7:0] seed, input int len,
                            input int cfg, input bit gap, input bit close);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sor   = (i == 0);
            in_eor   = close && (i == len - 1);
            in_data  = gen(pat, seed, i);
            cfg_len  = 15'(cfg);
            rowbuf[i] = in_data;
            if (gap && (i % 3 == 2) && (i != len - 1)) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_data  = 32'h7F00_0000;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sor   = 1'b0;
        in_eor   = 1'b0;
    endtask

    task automatic check_row(input int len, input int cfg, input string tag);
        logic [255:0] e;
        bit exp_err;
        build_expect(len);
        for (int k = 0; k < 8; k++) e[k*32 +: 32] = expv[k];
        exp_err = (len < 8) || (len > 16384) || (len != cfg);
        check1(top_vals == e, {tag, " values"}, top_vals, e);
        check1(done == 1'b1, "R7 done high after last", 256'(done), 256'(1));
        check1(err == exp_err, {tag, " err"}, 256'(err), 256'(exp_err));
        @(negedge clk);
        check1(done == 1'b0, "R7 done single cycle", 256'(done), 256'(0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [255:0] snap;
        logic         esnap;
        repeat (3) @(negedge clk);
        // R13: reset state
        check1(done == 1'b0 && err == 1'b0, "R13 reset flags", {254'd0, done, err}, 256'd0);
        check1(top_vals == {8{FLOOR}}, "R13 reset entries", top_vals, {8{FLOOR}});
        rst_n = 1'b1;
        @(negedge clk);

        // Table of rows: R1 R2 R3 R4 R5 R6 R9 R11
        for (int r = 0; r < N_ROWS; r++) begin
            send_row(ROWS[r].pat, ROWS[r].seed, int'(ROWS[r].len), int'(ROWS[r].cfg), ROWS[r].gap, 1'b1);
            check_row(int'(ROWS[r].len), int'(ROWS[r].cfg), "R1/R2/R3/R4/R5/R6/R9/R11 row");
        end

        // R8: stray elements after completion are ignored, results hold
        snap  = top_vals;
        esnap = err;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_eor   = (i == 5);
            in_data  = 32'h7F00_0000 + 32'(i);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_eor   = 1'b0;
        check1(top_vals == snap, "R8 values held", top_vals, snap);
        check1(err == esnap && done == 1'b0, "R8 err held no done", {254'd0, err, done}, {254'd0, esnap, 1'b0});

        // R12: abandon a row mid-stream, then a fresh row
        send_row(3'd0, 8'd11, 5, 10, 1'b0, 1'b0);
        send_row(3'd1, 8'd12, 12, 12, 1'b0, 1'b1);
        check_row(12, 12, "R12 restart");

        // R10: length boundaries
        send_row(3'd2, 8'd13, 8, 8, 1'b0, 1'b1);
        check_row(8, 8, "R10 len 8");
        send_row(3'd2, 8'd14, 16384, 16384, 1'b0, 1'b1);
        check_row(16384, 16384, "R10 len 16384");
        send_row(3'd0, 8'd15, 16385, 16385, 1'b0, 1'b1);
        check_row(16385, 16385, "R10 len 16385");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule